// File: doc/BRIEF.md
# Dual Oscillator Warm-Up Status Controller

This block times the warm-up of two crystal oscillators: a main one and a slower sub one. Each oscillator has its own warm-up counter. The counter restarts from zero whenever its oscillator is switched off or restarted. When the counter reaches a delay length picked by a static option input, the oscillator's ready flag is raised. The two ready flags are passed through a two-flop synchronizer into the CPU clock domain. There they appear in a read-only status byte and drive the outputs `mainReady` and `subReady`.

Each counter advances only on cycles where that oscillator's tick input is high. The tick stands for one sampled cycle of the oscillator. This keeps the whole block in one clock domain. The main flag comes up set after power-on reset with no wait. The sub flag starts cleared. The block also holds the clock-source select bit. A software write that tries to move the CPU onto the crystal is dropped while the main ready flag, as seen in the CPU domain, is clear.

Top module: `osc_warmup_status`

## Requirements
- R1: During reset and for the first two cycles after reset `statusByte` reads 00h and `clkSelXtal` is 0. With no clear event, `mainReady` becomes 1 two cycles after reset release and `subReady` stays 0.
- R2: With `mainLongSel`=0, the main flag sets on the 4096th tick counted since the last main clear.
- R3: With `mainLongSel`=1, the main flag sets on the 65536th tick counted since the last main clear.
- R4: The sub flag sets on the 1024th sub tick (`subLongSel`=0) or the 65536th sub tick (`subLongSel`=1) since the last sub clear.
- R5: `pdExit` high or `mainOff` high in a cycle clears the main flag and counter. While `mainOff` is held, main ticks are ignored and the flag stays 0.
- R6: `subOff` high clears only the sub flag and counter. Main state is unaffected by `subOff`, and sub state is unaffected by `pdExit` and `mainOff`.
- R7: Cycles with the tick low do not advance a counter.
- R8: `statusByte` bit 7 is the synchronized sub flag and bit 4 is the synchronized main flag. Bits 6, 5 and 3..0 read 0.
- R9: A write (`selWrEn`=1) of `selWrData`=1 updates `clkSelXtal` only if `mainReady` is 1 in that cycle; otherwise it is ignored. A write of 0 always takes effect. `clkSelXtal` updates on the edge that samples the write.
- R10: A change of an internal flag at clock edge k appears on `mainReady`/`subReady` and `statusByte` after edge k+2.
- R11: Once set, a flag holds through any number of further ticks until its next clear event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-domain clock |
| rstN | input | 1 | Active-low power-on reset |
| mainTick | input | 1 | One sampled main-oscillator cycle |
| subTick | input | 1 | One sampled sub-oscillator cycle |
| mainOff | input | 1 | Main oscillator off control |
| subOff | input | 1 | Sub oscillator off control |
| pdExit | input | 1 | Power-down exit pulse (restarts main oscillator) |
| mainLongSel | input | 1 | Static option: 1 = long main delay |
| subLongSel | input | 1 | Static option: 1 = long sub delay |
| selWrEn | input | 1 | Software write strobe for clock-source bit |
| selWrData | input | 1 | Value written; 1 = crystal |
| mainReady | output | 1 | Synchronized main ready flag |
| subReady | output | 1 | Synchronized sub ready flag |
| statusByte | output | 8 | Status register contents |
| clkSelXtal | output | 1 | Clock-source select bit |

## Verification
The bench targets the exact terminal tick in each delay mode. A counter that is off by one would show the flag one tick early or late. It checks the synchronizer latency around reset, where the flag is set internally but the status byte must still read 00h. It checks a crystal-select write attempted during warm-up and one attempted in the first cycles after reset; a design that tested the unsynchronized flag or skipped the gate would switch early. It also checks cross-talk between the two clear sources, and sparse tick patterns that a cycle-counting design would finish too soon.

// File: rtl/owu_pkg.sv
package owu_pkg;
  localparam int OSC_COUNT = 2;
  localparam int MAIN_IDX  = 0;
  localparam int SUB_IDX   = 1;

  typedef struct packed {
    logic clear;
    logic tick;
    logic longSel;
  } timer_ctl_t;

  typedef struct packed {
    timer_ctl_t [OSC_COUNT-1:0] osc;
  } warm_strobes_t;
endpackage

// File: rtl/owu_warmup_timer.sv
module owu_warmup_timer
  import owu_pkg::*;
#(
  parameter int SHORT_LOG    = 12,
  parameter int LONG_LOG     = 16,
  parameter bit READY_AT_POR = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  timer_ctl_t ctl,
  output logic       rawReady
);
  localparam int CW = LONG_LOG + 1;
  localparam logic [CW-1:0] LONG_TERM  = CW'(1) << LONG_LOG;
  localparam logic [CW-1:0] SHORT_TERM = CW'(1) << SHORT_LOG;

  logic [CW-1:0] count;
  logic [CW-1:0] nextCount;
  logic [CW-1:0] terminal;

  assign terminal  = ctl.longSel ? LONG_TERM : SHORT_TERM;
  assign nextCount = count + CW'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      rawReady <= READY_AT_POR;
    end else if (ctl.clear) begin
      count    <= '0;
      rawReady <= 1'b0;
    end else if (ctl.tick && !rawReady) begin
      count <= nextCount;
      if (nextCount == terminal) rawReady <= 1'b1;
    end
  end

  // R5 / R6: a clear empties counter and flag on the next cycle
  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> (count == '0 && !rawReady));

  // R2 / R3 / R4: the flag rises only with the counter at its terminal value
  p_set_at_terminal_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rawReady) |-> (count == terminal));

  // R7: the counter never runs past the longest delay
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    count <= LONG_TERM);

  // R11: a set flag persists until a clear
  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rawReady && !ctl.clear) |=> rawReady);
endmodule

// File: rtl/owu_datapath.sv
module owu_datapath
  import owu_pkg::*;
#(
  parameter int MAIN_SHORT_LOG = 12,
  parameter int SUB_SHORT_LOG  = 10,
  parameter int LONG_LOG       = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  warm_strobes_t        strobes,
  output logic [OSC_COUNT-1:0] readySync,
  output logic [7:0]           statusByte
);
  logic [OSC_COUNT-1:0] rawReady;
  logic [OSC_COUNT-1:0] syncStage1;

  for (genvar i = 0; i < OSC_COUNT; i++) begin : g_osc
    localparam int SL = (i == MAIN_IDX) ? MAIN_SHORT_LOG : SUB_SHORT_LOG;
    localparam bit PR = (i == MAIN_IDX);

    owu_warmup_timer #(
      .SHORT_LOG   (SL),
      .LONG_LOG    (LONG_LOG),
      .READY_AT_POR(PR)
    ) u_timer (
      .clk     (clk),
      .rstN    (rstN),
      .ctl     (strobes.osc[i]),
      .rawReady(rawReady[i])
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncStage1[i] <= 1'b0;
        readySync[i]  <= 1'b0;
      end else begin
        syncStage1[i] <= rawReady[i];
        readySync[i]  <= syncStage1[i];
      end
    end

    // R10: synchronized flag follows the raw flag two edges later
    p_sync_rise_r10: assert property (@(posedge clk) disable iff (!rstN)
      $rose(readySync[i]) |-> $past(rawReady[i], 2));
    p_sync_fall_r10: assert property (@(posedge clk) disable iff (!rstN)
      $fell(readySync[i]) |-> !$past(rawReady[i], 2));
  end

  assign statusByte = {readySync[SUB_IDX], 2'b00, readySync[MAIN_IDX], 4'h0};
endmodule

// File: rtl/owu_control.sv
module owu_control
  import owu_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          mainTick,
  input  logic          subTick,
  input  logic          mainOff,
  input  logic          subOff,
  input  logic          pdExit,
  input  logic          mainLongSel,
  input  logic          subLongSel,
  input  logic          selWrEn,
  input  logic          selWrData,
  input  logic          mainReadySync,
  output warm_strobes_t strobes,
  output logic          clkSelXtal
);
  logic selAccept;

  always_comb begin
    strobes.osc[MAIN_IDX].clear   = mainOff | pdExit;
    strobes.osc[MAIN_IDX].tick    = mainTick;
    strobes.osc[MAIN_IDX].longSel = mainLongSel;
    strobes.osc[SUB_IDX].clear    = subOff;
    strobes.osc[SUB_IDX].tick     = subTick;
    strobes.osc[SUB_IDX].longSel  = subLongSel;
  end

  assign selAccept = selWrEn && (!selWrData || mainReadySync);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          clkSelXtal <= 1'b0;
    else if (selAccept) clkSelXtal <= selWrData;
  end

  // R9: crystal selection only while the main oscillator is ready
  p_sel_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkSelXtal) |-> $past(mainReadySync));

  // R9: writing 0 always returns to the RC source
  p_sel_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (selWrEn && !selWrData) |=> !clkSelXtal);
endmodule

// File: rtl/osc_warmup_status.sv
module osc_warmup_status
  import owu_pkg::*;
#(
  parameter int MAIN_SHORT_LOG = 12,
  parameter int SUB_SHORT_LOG  = 10,
  parameter int LONG_LOG       = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       mainTick,
  input  logic       subTick,
  input  logic       mainOff,
  input  logic       subOff,
  input  logic       pdExit,
  input  logic       mainLongSel,
  input  logic       subLongSel,
  input  logic       selWrEn,
  input  logic       selWrData,
  output logic       mainReady,
  output logic       subReady,
  output logic [7:0] statusByte,
  output logic       clkSelXtal
);
  warm_strobes_t        strobes;
  logic [OSC_COUNT-1:0] readySync;

  owu_control u_control (
    .clk          (clk),
    .rstN         (rstN),
    .mainTick     (mainTick),
    .subTick      (subTick),
    .mainOff      (mainOff),
    .subOff       (subOff),
    .pdExit       (pdExit),
    .mainLongSel  (mainLongSel),
    .subLongSel   (subLongSel),
    .selWrEn      (selWrEn),
    .selWrData    (selWrData),
    .mainReadySync(readySync[MAIN_IDX]),
    .strobes      (strobes),
    .clkSelXtal   (clkSelXtal)
  );

  owu_datapath #(
    .MAIN_SHORT_LOG(MAIN_SHORT_LOG),
    .SUB_SHORT_LOG (SUB_SHORT_LOG),
    .LONG_LOG      (LONG_LOG)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .readySync (readySync),
    .statusByte(statusByte)
  );

  assign mainReady = readySync[MAIN_IDX];
  assign subReady  = readySync[SUB_IDX];
endmodule

// File: tb/osc_warmup_status_bench.sv
module osc_warmup_status_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mainTick = 0, subTick = 0, mainOff = 0, subOff = 0, pdExit = 0;
  logic mainLongSel = 0, subLongSel = 0, selWrEn = 0, selWrData = 0;
  logic mainReady, subReady, clkSelXtal;
  logic [7:0] statusByte;

  int checks = 0;
  int failures = 0;
  int mismatches = 0;
  logic [7:0] firstAct = 0, firstExp = 0;

  // reference model state
  int mCnt, sCnt;
  bit mRaw, sRaw, mS1, mS2, sS1, sS2, mSel;

  always #2.5 clk = ~clk;

  osc_warmup_status u_osc_warmup_status (
    .clk(clk), .rstN(rstN), .mainTick(mainTick), .subTick(subTick),
    .mainOff(mainOff), .subOff(subOff), .pdExit(pdExit),
    .mainLongSel(mainLongSel), .subLongSel(subLongSel),
    .selWrEn(selWrEn), .selWrData(selWrData),
    .mainReady(mainReady), .subReady(subReady),
    .statusByte(statusByte), .clkSelXtal(clkSelXtal)
  );

  function automatic logic [7:0] expStatus();
    return {sS2, 2'b00, mS2, 4'h0};
  endfunction

  function automatic logic [7:0] expOuts();
    return {4'h0, mS2, sS2, mSel, 1'b0};
  endfunction

  function automatic logic [7:0] actOuts();
    return {4'h0, mainReady, subReady, clkSelXtal, 1'b0};
  endfunction

  task automatic modelReset();
    mCnt = 0; sCnt = 0; mRaw = 1; sRaw = 0;
    mS1 = 0; mS2 = 0; sS1 = 0; sS2 = 0; mSel = 0;
  endtask

  task automatic modelStep();
    int mTerm, sTerm;
    mTerm = mainLongSel ? 65536 : 4096;
    sTerm = subLongSel ? 65536 : 1024;
    if (selWrEn && (!selWrData || mS2)) mSel = selWrData;
    mS2 = mS1; mS1 = mRaw;
    sS2 = sS1; sS1 = sRaw;
    if (mainOff || pdExit) begin mCnt = 0; mRaw = 0; end
    else if (mainTick && !mRaw) begin mCnt++; if (mCnt == mTerm) mRaw = 1; end
    if (subOff) begin sCnt = 0; sRaw = 0; end
    else if (subTick && !sRaw) begin sCnt++; if (sCnt == sTerm) sRaw = 1; end
  endtask

  task automatic cycle();
    @(posedge clk);
    if (rstN) modelStep(); else modelReset();
    @(negedge clk);
    if (rstN && (statusByte !== expStatus() || actOuts() !== expOuts())) begin
      if (mismatches == 0) begin firstAct = statusByte; firstExp = expStatus(); end
      mismatches++;
    end
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkModel(string tag);
    chk({tag, " status"}, statusByte, expStatus());
    chk({tag, " outs"}, actOuts(), expOuts());
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    modelReset();
    @(negedge clk);
    cycles(3);
    chk("R1 status in reset", statusByte, 8'h00);
    rstN = 1'b1;
    // R9: write of 1 in the first cycle after reset is ignored
    selWrEn = 1; selWrData = 1;
    cycle();
    selWrEn = 0;
    chk("R1 status one cycle after reset", statusByte, 8'h00);
    chk("R9 sel write ignored before ready", {7'h0, clkSelXtal}, 8'h00);
    cycle();
    chk("R1 R8 main ready after POR", statusByte, 8'h10);
    chk("R1 sub not ready", {7'h0, subReady}, 8'h00);
    selWrEn = 1; selWrData = 1; cycle(); selWrEn = 0;
    chk("R9 sel write accepted when ready", {7'h0, clkSelXtal}, 8'h01);
    selWrEn = 1; selWrData = 0; cycle(); selWrEn = 0;
    chk("R9 sel write 0 accepted", {7'h0, clkSelXtal}, 8'h00);

    // R5: off held with ticks -> flag drops, stays 0
    mainOff = 1; mainTick = 1;
    cycles(3);
    chk("R5 main cleared by off", {7'h0, mainReady}, 8'h00);
    cycles(20);
    chk("R5 ticks ignored while off", {7'h0, mainReady}, 8'h00);
    mainOff = 0;
    // R2: short main delay, exact terminal tick
    cycles(4095);
    mainTick = 0;
    selWrEn = 1; selWrData = 1; cycle(); selWrEn = 0;
    chk("R9 sel write ignored during warm-up", {7'h0, clkSelXtal}, 8'h00);
    cycles(5);
    chk("R2 R7 not ready after 4095 ticks", {7'h0, mainReady}, 8'h00);
    mainTick = 1; cycle(); mainTick = 0;
    chk("R10 not visible at edge k", {7'h0, mainReady}, 8'h00);
    cycle();
    chk("R10 not visible at edge k+1", {7'h0, mainReady}, 8'h00);
    cycle();
    chk("R2 R10 ready at edge k+2", statusByte, 8'h10);
    mainTick = 1; cycles(300); mainTick = 0;
    chk("R11 main holds ready", {7'h0, mainReady}, 8'h01);

    // R6 R7: sub short delay with sparse ticks
    subOff = 1; cycle(); subOff = 0;
    for (int i = 0; i < 1023; i++) begin subTick = 1; cycle(); subTick = 0; cycle(); end
    cycles(3);
    chk("R4 R7 sub not ready after 1023 sparse ticks", {7'h0, subReady}, 8'h00);
    subTick = 1; cycle(); subTick = 0; cycles(2);
    chk("R4 R8 sub ready after 1024 ticks", statusByte, 8'h90);

    // R5 R6: pdExit clears main only; subOff clears sub only
    pdExit = 1; cycle(); pdExit = 0; cycles(2);
    chk("R5 R6 pdExit clears main only", statusByte, 8'h80);
    mainTick = 1; cycles(4096); mainTick = 0; cycles(2);
    chk("R2 main ready again", statusByte, 8'h90);
    subOff = 1; cycle(); subOff = 0; cycles(2);
    chk("R6 subOff clears sub only", statusByte, 8'h10);

    // R3 R4: long delays on both
    mainOff = 1; subOff = 1; mainLongSel = 1; subLongSel = 1; cycle();
    mainOff = 0; subOff = 0; mainTick = 1; subTick = 1;
    cycles(65535);
    mainTick = 0; subTick = 0; cycles(3);
    chk("R3 R4 not ready after 65535 ticks", statusByte, 8'h00);
    mainTick = 1; subTick = 1; cycle(); mainTick = 0; subTick = 0; cycles(2);
    chk("R3 R4 ready after 65536 ticks", statusByte, 8'h90);
    chkModel("R3 model after long");

    // random phase with short delays
    mainOff = 1; subOff = 1; mainLongSel = 0; subLongSel = 0; cycle();
    mainOff = 0; subOff = 0;
    for (int i = 0; i < 20000; i++) begin
      mainTick  = ($urandom % 4) != 0;
      subTick   = ($urandom % 4) != 0;
      mainOff   = ($urandom % 3000) == 0;
      subOff    = ($urandom % 2000) == 0;
      pdExit    = ($urandom % 3000) == 0;
      selWrEn   = ($urandom % 50) == 0;
      selWrData = $urandom % 2;
      cycle();
      if (i % 4000 == 3999) chkModel("R5 R6 R9 random phase");
    end
    mainTick = 0; subTick = 0; mainOff = 0; subOff = 0; pdExit = 0; selWrEn = 0;
    cycles(3);
    chkModel("R8 final");
    chk("R10 cycle model tracking (first mismatch status)",
        (mismatches == 0) ? 8'h00 : firstAct, (mismatches == 0) ? 8'h00 : firstExp);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule